// File: doc/BRIEF.md
# Compression-Aware Video Timing Generator

This block produces the raster timing for one display output. From programmed sync pulse widths, porches, active sizes and a start skew, it drives horizontal sync, vertical sync, display enable, an active-area window and a separate data-valid strobe. The whole frame is tracked by a single linear pixel-clock counter. A line-position counter runs beside it. Every window is decided by comparing these two counters against bounds that are derived from the settings.

The data-valid strobe can be shorter than display enable. Its length depends on three things: whether the link carries compressed data, whether the double-width data bus is in use, and whether the output is in DP style. In DP style the vertical display window is shifted and the horizontal display window is replaced by the active span. A TE-alignment option holds the frame counter at zero after enable until an external tearing-effect pulse arrives.

Settings are captured only while the generator is disabled. While it is enabled they stay frozen.

Top module: `vtg_top`

## Requirements
- R1: Line length is htot = h_pulse + h_back + h_width + h_front clocks. Frame length is vtot x htot clocks, where vtot = v_pulse + v_back + v_height + v_front. The sync output is active for the first h_pulse clocks of every line, and the counter wraps to pixel 0 after the last pixel of the frame.
- R2: Vertical sync is active for the first v_pulse x htot clocks of each frame.
- R3: Outside DP mode, display enable is high when both of these hold:
  - the line position x lies in [h_pulse+h_back, htot-h_front-1];
  - the frame pixel index c satisfies (v_pulse+v_back) x htot + skew <= c < (vtot-v_front) x htot + skew.
- R4: The active window is high when both of these hold:
  - x lies in [hs, hs+x_res-1], where hs = h_pulse+h_back;
  - c lies in [vs0, vs0 + y_res x htot - 1], where vs0 is the vertical display start in effect.
- R5: When compression is on and the wide bus is off, data_valid equals display enable.
- R6: When compression is on and the wide bus is on, outside DP mode, data_valid is high inside the vertical display window for ceil(comp_bytes/6) pixels starting at x = hs.
- R7: When compression is off, data_valid spans h_width/2 pixels (wide bus, not DP) or h_width pixels (all other cases), starting at x = hs and inside the vertical display window.
- R8: In DP mode the vertical display start grows by h_pulse+h_back and the vertical display end shrinks by h_front. Horizontally, display enable covers [hs, hs+x_res-1].
- R9: In DP mode with compression and the wide bus, data_valid covers x in [hs, hs+dp_extra] inside the vertical display window.
- R10: pol_word is {1'b0, vsync inversion, hsync inversion}. In HDMI mode the hsync inversion is 0 when y_res >= 720 and 1 otherwise; outside HDMI mode it follows cfg_hs_inv. An inversion bit of 1 makes the sync output idle high and pulse low.
- R11: With TE alignment on, the outputs stay idle after enable until te_in is seen high. The first frame pixel is output two clocks after te_in is sampled.
- R12: Settings are sampled only while enable is low. Without TE alignment, pixel 0 appears on the outputs two clocks after enable is sampled high. From two clocks after enable falls, display enable, active window and data_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator |
| te_in | input | 1 | External tearing-effect pulse |
| cfg_te_align | input | 1 | Wait for te_in before starting the frame |
| cfg_dp | input | 1 | DP-style window placement |
| cfg_hdmi | input | 1 | HDMI polarity rule |
| cfg_comp | input | 1 | Compressed data carried |
| cfg_wide | input | 1 | Double-width data bus |
| cfg_hs_inv | input | 1 | Hsync inversion outside HDMI mode |
| cfg_vs_inv | input | 1 | Vsync inversion |
| h_pulse | input | CW | Hsync pulse width |
| h_back | input | CW | Horizontal back porch |
| h_width | input | CW | Horizontal active width |
| h_front | input | CW | Horizontal front porch |
| v_pulse | input | CW | Vsync pulse width in lines |
| v_back | input | CW | Vertical back porch in lines |
| v_height | input | CW | Vertical active height in lines |
| v_front | input | CW | Vertical front porch in lines |
| skew | input | CW | Display start skew in clocks |
| x_res | input | CW | Active window width |
| y_res | input | CW | Active window height |
| comp_bytes | input | BW | Compressed bytes per line |
| dp_extra | input | CW | DP compressed data extra cycles |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| disp_en | output | 1 | Display enable |
| active_win | output | 1 | Active window |
| data_valid | output | 1 | Data-valid strobe |
| pol_word | output | 3 | Polarity word {den, vsync, hsync} |

## Verification
On every cycle, the assertions check four things:
- the line counter stays below the line length;
- the frame counter wraps exactly at the end of the frame;
- disabling the generator idles the counter, and the window outputs go low one clock later;
- settings hold steady while the generator runs, and the generator stays idle while it waits for TE.

The exact placement of each window is checked only by the bench, pixel by pixel, against a model built from the requirements. This covers skew, the DP shifts, the four data-width rules, the HDMI polarity choice and the first-pixel latency after enable or TE.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef struct packed {
        logic te_align;
        logic dp;
        logic hdmi;
        logic comp;
        logic wide;
        logic hs_inv;
        logic vs_inv;
    } vtg_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } vtg_state_e;

endpackage

// File: rtl/vtg_cfg.sv
module vtg_cfg
    import vtg_pkg::*;
#(
    parameter int CW = 12,
    parameter int BW = 16,
    parameter int HW = CW + 2,
    parameter int FW = 2 * HW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  vtg_mode_t       mode_in,
    input  logic [CW-1:0]   h_pulse,
    input  logic [CW-1:0]   h_back,
    input  logic [CW-1:0]   h_width,
    input  logic [CW-1:0]   h_front,
    input  logic [CW-1:0]   v_pulse,
    input  logic [CW-1:0]   v_back,
    input  logic [CW-1:0]   v_height,
    input  logic [CW-1:0]   v_front,
    input  logic [CW-1:0]   skew,
    input  logic [CW-1:0]   x_res,
    input  logic [CW-1:0]   y_res,
    input  logic [BW-1:0]   comp_bytes,
    input  logic [CW-1:0]   dp_extra,
    output vtg_mode_t       mode,
    output logic [HW-1:0]   htot,
    output logic [FW-1:0]   frame_len,
    output logic [FW:0]     vs_lim,
    output logic [HW-1:0]   hd_lo,
    output logic [HW-1:0]   hd_hi,
    output logic [HW-1:0]   act_hi,
    output logic [HW:0]     dv_lim,
    output logic [FW:0]     vd_lo,
    output logic [FW:0]     vd_lim,
    output logic [FW:0]     act_vlim,
    output logic            sep_data,
    output logic            hpol,
    output logic            vpol
);
    localparam int VW = FW + 1;

    typedef struct packed {
        logic [CW-1:0] hp, hbp, hw, hfp, vp, vbp, vh, vfp, skw, xr, yr, ext;
        logic [BW-1:0] bpl;
        vtg_mode_t     md;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!enable) begin
            cfg_d.hp  = h_pulse;
            cfg_d.hbp = h_back;
            cfg_d.hw  = h_width;
            cfg_d.hfp = h_front;
            cfg_d.vp  = v_pulse;
            cfg_d.vbp = v_back;
            cfg_d.vh  = v_height;
            cfg_d.vfp = v_front;
            cfg_d.skw = skew;
            cfg_d.xr  = x_res;
            cfg_d.yr  = y_res;
            cfg_d.ext = dp_extra;
            cfg_d.bpl = comp_bytes;
            cfg_d.md  = mode_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    logic [HW-1:0] vtot;
    logic [BW:0]   bpl_div6;
    logic [HW-1:0] dwidth;
    logic [VW-1:0] vstart_base, vend_base;

    always_comb begin
        mode      = cfg_q.md;
        htot      = HW'(cfg_q.hp) + HW'(cfg_q.hbp) + HW'(cfg_q.hw) + HW'(cfg_q.hfp);
        vtot      = HW'(cfg_q.vp) + HW'(cfg_q.vbp) + HW'(cfg_q.vh) + HW'(cfg_q.vfp);
        frame_len = FW'(vtot) * FW'(htot);
        vs_lim    = VW'(FW'(cfg_q.vp) * FW'(htot));
        hd_lo     = HW'(cfg_q.hp) + HW'(cfg_q.hbp);
        act_hi    = hd_lo + HW'(cfg_q.xr) - HW'(1);
        hd_hi     = cfg_q.md.dp ? act_hi : (htot - HW'(cfg_q.hfp) - HW'(1));

        vstart_base = VW'(FW'(HW'(cfg_q.vp) + HW'(cfg_q.vbp)) * FW'(htot)) + VW'(cfg_q.skw);
        vend_base   = VW'(FW'(vtot - HW'(cfg_q.vfp)) * FW'(htot)) + VW'(cfg_q.skw);
        if (cfg_q.md.dp) begin
            vd_lo  = vstart_base + VW'(hd_lo);
            vd_lim = vend_base - VW'(cfg_q.hfp);
        end else begin
            vd_lo  = vstart_base;
            vd_lim = vend_base;
        end
        act_vlim = vd_lo + VW'(FW'(cfg_q.yr) * FW'(htot));

        bpl_div6 = ({1'b0, cfg_q.bpl} + (BW+1)'(5)) / (BW+1)'(6);
        if (cfg_q.md.comp)
            dwidth = HW'(bpl_div6);
        else if (cfg_q.md.wide && !cfg_q.md.dp)
            dwidth = HW'(cfg_q.hw >> 1);
        else
            dwidth = HW'(cfg_q.hw);

        if (cfg_q.md.dp && cfg_q.md.comp)
            dv_lim = {1'b0, hd_lo} + (HW+1)'(cfg_q.ext) + (HW+1)'(1);
        else
            dv_lim = {1'b0, hd_lo} + {1'b0, dwidth};

        sep_data = !cfg_q.md.comp || cfg_q.md.wide;
        hpol     = cfg_q.md.hdmi ? (cfg_q.yr < CW'(720)) : cfg_q.md.hs_inv;
        vpol     = cfg_q.md.vs_inv;
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> $stable(cfg_q)); // R12

endmodule

// File: rtl/vtg_counter.sv
module vtg_counter
    import vtg_pkg::*;
#(
    parameter int HW = 14,
    parameter int FW = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          te_in,
    input  logic          te_align,
    input  logic [HW-1:0] htot,
    input  logic [FW-1:0] frame_len,
    output logic          run,
    output logic [FW-1:0] cnt,
    output logic [HW-1:0] hx
);
    typedef struct packed {
        vtg_state_e    st;
        logic [FW-1:0] c;
        logic [HW-1:0] x;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!enable) begin
            cnt_d.st = ST_IDLE;
            cnt_d.c  = '0;
            cnt_d.x  = '0;
        end else begin
            case (cnt_q.st)
                ST_IDLE: begin
                    cnt_d.c  = '0;
                    cnt_d.x  = '0;
                    cnt_d.st = te_align ? ST_WAIT : ST_RUN;
                end
                ST_WAIT: begin
                    if (te_in) cnt_d.st = ST_RUN;
                end
                ST_RUN: begin
                    if (cnt_q.c == frame_len - FW'(1)) begin
                        cnt_d.c = '0;
                        cnt_d.x = '0;
                    end else begin
                        cnt_d.c = cnt_q.c + FW'(1);
                        cnt_d.x = (cnt_q.x == htot - HW'(1)) ? '0 : cnt_q.x + HW'(1);
                    end
                end
                default: cnt_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '{st: ST_IDLE, c: '0, x: '0};
        else        cnt_q <= cnt_d;
    end

    assign run = (cnt_q.st == ST_RUN);
    assign cnt = cnt_q.c;
    assign hx  = cnt_q.x;

    AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (hx < htot)); // R1
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && run && cnt == frame_len - FW'(1)) |=> (cnt == '0 && hx == '0)); // R1
    AST_TE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cnt_q.st == ST_WAIT && !te_in) |=> (!run && cnt == '0)); // R11
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!run && cnt == '0)); // R12

endmodule

// File: rtl/vtg_decode.sv
module vtg_decode #(
    parameter int HW = 14,
    parameter int FW = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [FW-1:0] cnt,
    input  logic [HW-1:0] hx,
    input  logic [HW-1:0] hp_lim,
    input  logic [FW:0]   vs_lim,
    input  logic [HW-1:0] hd_lo,
    input  logic [HW-1:0] hd_hi,
    input  logic [HW-1:0] act_hi,
    input  logic [HW:0]   dv_lim,
    input  logic [FW:0]   vd_lo,
    input  logic [FW:0]   vd_lim,
    input  logic [FW:0]   act_vlim,
    input  logic          sep_data,
    input  logic          hpol,
    input  logic          vpol,
    output logic          hsync,
    output logic          vsync,
    output logic          disp_en,
    output logic          active_win,
    output logic          data_valid
);
    typedef struct packed {
        logic hs, vs, de, act, dv, ran;
    } out_t;

    out_t out_d, out_q;
    logic [FW:0] c_ext;
    logic        h_in, v_in, h_act, v_act, h_dat;

    always_comb begin
        c_ext = {1'b0, cnt};
        h_in  = (hx >= hd_lo) && (hx <= hd_hi);
        v_in  = (c_ext >= vd_lo) && (c_ext < vd_lim);
        h_act = (hx >= hd_lo) && (hx <= act_hi);
        v_act = (c_ext >= vd_lo) && (c_ext < act_vlim);
        h_dat = (hx >= hd_lo) && ({1'b0, hx} < dv_lim);

        out_d.ran = run;
        if (run) begin
            out_d.hs  = (hx < hp_lim) ^ hpol;
            out_d.vs  = (c_ext < vs_lim) ^ vpol;
            out_d.de  = h_in && v_in;
            out_d.act = h_act && v_act;
            out_d.dv  = sep_data ? (h_dat && v_in) : (h_in && v_in);
        end else begin
            out_d.hs  = hpol;
            out_d.vs  = vpol;
            out_d.de  = 1'b0;
            out_d.act = 1'b0;
            out_d.dv  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign hsync      = out_q.hs;
    assign vsync      = out_q.vs;
    assign disp_en    = out_q.de;
    assign active_win = out_q.act;
    assign data_valid = out_q.dv;

    AST_IDLE_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_q.ran |-> (!disp_en && !active_win && !data_valid)); // R12

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int CW = 12,
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          te_in,
    input  logic          cfg_te_align,
    input  logic          cfg_dp,
    input  logic          cfg_hdmi,
    input  logic          cfg_comp,
    input  logic          cfg_wide,
    input  logic          cfg_hs_inv,
    input  logic          cfg_vs_inv,
    input  logic [CW-1:0] h_pulse,
    input  logic [CW-1:0] h_back,
    input  logic [CW-1:0] h_width,
    input  logic [CW-1:0] h_front,
    input  logic [CW-1:0] v_pulse,
    input  logic [CW-1:0] v_back,
    input  logic [CW-1:0] v_height,
    input  logic [CW-1:0] v_front,
    input  logic [CW-1:0] skew,
    input  logic [CW-1:0] x_res,
    input  logic [CW-1:0] y_res,
    input  logic [BW-1:0] comp_bytes,
    input  logic [CW-1:0] dp_extra,
    output logic          hsync,
    output logic          vsync,
    output logic          disp_en,
    output logic          active_win,
    output logic          data_valid,
    output logic [2:0]    pol_word
);
    localparam int HW = CW + 2;
    localparam int FW = 2 * HW;

    vtg_mode_t     mode_in, mode;
    logic [HW-1:0] htot, hd_lo, hd_hi, act_hi, hx;
    logic [FW-1:0] frame_len, cnt;
    logic [FW:0]   vs_lim, vd_lo, vd_lim, act_vlim;
    logic [HW:0]   dv_lim;
    logic          sep_data, hpol, vpol, run;

    assign mode_in = '{te_align: cfg_te_align, dp: cfg_dp, hdmi: cfg_hdmi,
                       comp: cfg_comp, wide: cfg_wide,
                       hs_inv: cfg_hs_inv, vs_inv: cfg_vs_inv};

    vtg_cfg #(.CW(CW), .BW(BW), .HW(HW), .FW(FW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_in(mode_in),
        .h_pulse(h_pulse), .h_back(h_back), .h_width(h_width), .h_front(h_front),
        .v_pulse(v_pulse), .v_back(v_back), .v_height(v_height), .v_front(v_front),
        .skew(skew), .x_res(x_res), .y_res(y_res), .comp_bytes(comp_bytes),
        .dp_extra(dp_extra), .mode(mode), .htot(htot), .frame_len(frame_len),
        .vs_lim(vs_lim), .hd_lo(hd_lo), .hd_hi(hd_hi), .act_hi(act_hi),
        .dv_lim(dv_lim), .vd_lo(vd_lo), .vd_lim(vd_lim), .act_vlim(act_vlim),
        .sep_data(sep_data), .hpol(hpol), .vpol(vpol)
    );

    vtg_counter #(.HW(HW), .FW(FW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .enable(enable), .te_in(te_in),
        .te_align(mode.te_align), .htot(htot), .frame_len(frame_len),
        .run(run), .cnt(cnt), .hx(hx)
    );

    logic [HW-1:0] hp_lim;
    assign hp_lim = HW'(u_cfg.cfg_q.hp);

    vtg_decode #(.HW(HW), .FW(FW)) u_dec (
        .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .hx(hx),
        .hp_lim(hp_lim), .vs_lim(vs_lim), .hd_lo(hd_lo), .hd_hi(hd_hi),
        .act_hi(act_hi), .dv_lim(dv_lim), .vd_lo(vd_lo), .vd_lim(vd_lim),
        .act_vlim(act_vlim), .sep_data(sep_data), .hpol(hpol), .vpol(vpol),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .active_win(active_win), .data_valid(data_valid)
    );

    assign pol_word = {1'b0, vpol, hpol};

endmodule

// File: tb/vtg_top_tb.sv
module vtg_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 12;
    localparam int BW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, te_in = 1'b0;
    logic cfg_te_align = 0, cfg_dp = 0, cfg_hdmi = 0, cfg_comp = 0, cfg_wide = 0;
    logic cfg_hs_inv = 0, cfg_vs_inv = 0;
    logic [CW-1:0] h_pulse = 0, h_back = 0, h_width = 0, h_front = 0;
    logic [CW-1:0] v_pulse = 0, v_back = 0, v_height = 0, v_front = 0;
    logic [CW-1:0] skew = 0, x_res = 0, y_res = 0, dp_extra = 0;
    logic [BW-1:0] comp_bytes = 0;
    logic hsync, vsync, disp_en, active_win, data_valid;
    logic [2:0] pol_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    vtg_top #(.CW(CW), .BW(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .te_in(te_in),
        .cfg_te_align(cfg_te_align), .cfg_dp(cfg_dp), .cfg_hdmi(cfg_hdmi),
        .cfg_comp(cfg_comp), .cfg_wide(cfg_wide), .cfg_hs_inv(cfg_hs_inv),
        .cfg_vs_inv(cfg_vs_inv), .h_pulse(h_pulse), .h_back(h_back),
        .h_width(h_width), .h_front(h_front), .v_pulse(v_pulse), .v_back(v_back),
        .v_height(v_height), .v_front(v_front), .skew(skew), .x_res(x_res),
        .y_res(y_res), .comp_bytes(comp_bytes), .dp_extra(dp_extra),
        .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .active_win(active_win),
        .data_valid(data_valid), .pol_word(pol_word)
    );

    typedef struct {
        int hp, hbp, hw, hfp, vp, vbp, vh, vfp, skw, xr, yr, bpl, ext;
        bit te, dp, hdmi, comp, wide, hsi, vsi;
    } tcfg_t;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    function automatic int htot_of(tcfg_t c);
        return c.hp + c.hbp + c.hw + c.hfp;
    endfunction

    function automatic int frame_of(tcfg_t c);
        return htot_of(c) * (c.vp + c.vbp + c.vh + c.vfp);
    endfunction

    function automatic bit hpol_of(tcfg_t c);
        if (c.hdmi) return (c.yr < 720);
        return c.hsi;
    endfunction

    // expected {hsync, vsync, disp_en, active_win, data_valid} for pixel p
    function automatic logic [4:0] model(tcfg_t c, int p);
        int ht, vt, x, hs, he, vlo, vhi, dlim;
        bit s_h, s_v, hd, vd, de, act, dv;
        ht = htot_of(c);
        vt = c.vp + c.vbp + c.vh + c.vfp;
        x  = p % ht;
        s_h = (x < c.hp);                                  // R1
        s_v = (p < c.vp * ht);                             // R2
        hs  = c.hp + c.hbp;
        he  = ht - c.hfp - 1;
        vlo = (c.vp + c.vbp) * ht + c.skw;                 // R3
        vhi = (vt - c.vfp) * ht + c.skw;
        if (c.dp) begin                                    // R8
            vlo += c.hp + c.hbp;
            vhi -= c.hfp;
            he = hs + c.xr - 1;
        end
        hd = (x >= hs) && (x <= he);
        vd = (p >= vlo) && (p < vhi);
        de = hd && vd;
        act = (x >= hs) && (x <= hs + c.xr - 1) && (p >= vlo) && (p < vlo + c.yr * ht); // R4
        if (c.comp && !c.wide) dv = de;                    // R5
        else begin
            if (c.dp && c.comp) dlim = hs + c.ext + 1;     // R9
            else if (c.comp) dlim = hs + (c.bpl + 5) / 6;  // R6
            else if (c.wide && !c.dp) dlim = hs + c.hw / 2; // R7
            else dlim = hs + c.hw;
            dv = vd && (x >= hs) && (x < dlim);
        end
        return {s_h ^ hpol_of(c), s_v ^ c.vsi, de, act, dv};
    endfunction

    task automatic drive(tcfg_t c);
        h_pulse = CW'(c.hp); h_back = CW'(c.hbp); h_width = CW'(c.hw); h_front = CW'(c.hfp);
        v_pulse = CW'(c.vp); v_back = CW'(c.vbp); v_height = CW'(c.vh); v_front = CW'(c.vfp);
        skew = CW'(c.skw); x_res = CW'(c.xr); y_res = CW'(c.yr);
        comp_bytes = BW'(c.bpl); dp_extra = CW'(c.ext);
        cfg_te_align = c.te; cfg_dp = c.dp; cfg_hdmi = c.hdmi; cfg_comp = c.comp;
        cfg_wide = c.wide; cfg_hs_inv = c.hsi; cfg_vs_inv = c.vsi;
    endtask

    task automatic check(string tag, int p, logic [4:0] got, logic [4:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s pixel %0d: got %b expected %b", tag, p, got, exp);
        end
    endtask

    task automatic run_case(tcfg_t c, int frames, string tag, bit perturb);
        int fl;
        fl = frame_of(c);
        @(negedge clk);
        drive(c);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        enable = 1'b1;
        if (c.te) begin
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                // R11: idle while waiting for TE
                check({tag, " R11 wait"}, -1, {hsync, vsync, disp_en, active_win, data_valid},
                      {hpol_of(c), c.vsi, 3'b000});
            end
            te_in = 1'b1;
            @(negedge clk);
            te_in = 1'b0;
        end else begin
            @(negedge clk);
        end
        for (int k = 0; k < frames * fl; k++) begin
            @(negedge clk);
            if (perturb && k == 3) begin
                // R12: changes while enabled must be ignored
                h_front = h_front + CW'(3);
                cfg_comp = ~cfg_comp;
                y_res = y_res + CW'(1);
                skew = skew + CW'(2);
            end
            check(tag, k % fl, {hsync, vsync, disp_en, active_win, data_valid}, model(c, k % fl));
        end
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check({tag, " R12 disable"}, -1, {disp_en, active_win, data_valid}, 3'b000);
    endtask

    function automatic tcfg_t base();
        tcfg_t c;
        c.hp = 2; c.hbp = 3; c.hw = 12; c.hfp = 2;
        c.vp = 1; c.vbp = 2; c.vh = 4; c.vfp = 1;
        c.skw = 0; c.xr = 12; c.yr = 4; c.bpl = 30; c.ext = 4;
        c.te = 0; c.dp = 0; c.hdmi = 0; c.comp = 0; c.wide = 0; c.hsi = 0; c.vsi = 0;
        return c;
    endfunction

    initial begin
        tcfg_t c;
        int seed_dummy;
        seed_dummy = $urandom(32'd24681);
        c = base();
        c.hdmi = 1; c.yr = 480;
        drive(c);
        repeat (3) @(negedge clk);
        check("R12 reset windows", -1, {disp_en, active_win, data_valid}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R10: HDMI, y_res below 720 -> hsync inverted
        check("R10 pol 480", -1, {2'b00, pol_word}, 5'b00001);
        c.yr = 720;
        drive(c);
        @(negedge clk);
        @(negedge clk);
        check("R10 pol 720", -1, {2'b00, pol_word}, 5'b00000);

        c = base();                     run_case(c, 2, "R1 R2 R3 R4 R7 plain", 0);
        c = base(); c.skw = 3; c.hsi = 1; c.vsi = 1; c.xr = 8; c.yr = 2;
                                        run_case(c, 1, "R3 R4 R10 skew/inv", 0);
        c = base(); c.comp = 1;         run_case(c, 1, "R5 comp narrow", 0);
        c = base(); c.comp = 1; c.wide = 1; c.bpl = 31;
                                        run_case(c, 1, "R6 comp wide", 0);
        c = base(); c.comp = 1; c.wide = 1; c.bpl = 0;
                                        run_case(c, 1, "R6 comp zero bytes", 0);
        c = base(); c.wide = 1;         run_case(c, 1, "R7 wide halve", 0);
        c = base(); c.dp = 1; c.wide = 1; c.xr = 10;
                                        run_case(c, 1, "R8 dp wide", 0);
        c = base(); c.dp = 1; c.comp = 1; c.wide = 1; c.ext = 5; c.skw = 1;
                                        run_case(c, 1, "R9 dp comp", 0);
        c = base(); c.hdmi = 1; c.yr = 3;
                                        run_case(c, 1, "R10 hdmi", 0);
        c = base(); c.te = 1;           run_case(c, 1, "R11 te align", 0);
        c = base(); c.wide = 1;         run_case(c, 1, "R12 frozen", 1);

        for (int r = 0; r < 8; r++) begin
            c.hp = 1 + $urandom % 4;  c.hbp = $urandom % 5;
            c.hw = 4 + $urandom % 12; c.hfp = 1 + $urandom % 4;
            c.vp = 1 + $urandom % 2;  c.vbp = $urandom % 3;
            c.vh = 2 + $urandom % 4;  c.vfp = 1 + $urandom % 3;
            c.skw = $urandom % 4;     c.xr = 1 + $urandom % c.hw;
            c.yr = 1 + $urandom % c.vh; c.bpl = $urandom % 60;
            c.ext = $urandom % 8;
            c.te = $urandom % 2; c.dp = $urandom % 2; c.hdmi = $urandom % 2;
            c.comp = $urandom % 2; c.wide = $urandom % 2;
            c.hsi = $urandom % 2; c.vsi = $urandom % 2;
            run_case(c, 1, "R1 R3 R6 R7 R8 R9 random", r[0]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule